// File: doc/BRIEF.md
# Frame-Counting Receive FIFO Without Backpressure

This block buffers received bytes from a synchronous serial channel that cannot be paused. Frames arrive already delimited. Each written byte carries a start-of-frame flag and an end-of-frame flag. The writer is never told to wait. Every offered byte is stored, even when the buffer is already over capacity.

Alongside the byte memory, a small circular store records where each completed frame ends. The reader pulls bytes one at a time. It can also issue a frame-advance strobe, which retires the oldest stored frame and moves the read position to the start of the next frame.

An input frame counter, an output frame counter and the two byte pointers are always visible. Software derives the number of stored frames as the input frame counter minus the output frame counter, modulo the counter range. If that number drops between two polls with no frame retired in between, an overflow has occurred. A sticky overflow flag reports the same event directly. A dedicated FIFO clear is the only way to recover.

Top module: `frame_rx_fifo`

## Requirements
- R1: Every cycle with `wr_en` high stores the byte and moves `wbyte_cnt` on by one, modulo 2^ADDR_W. This holds whether or not overflow has occurred. No input ever stalls the writer. The only exception is set out in R9.
- R2: `fin_cnt` increases by one for each byte written with `wr_eof` high. `fout_cnt` increases by one for each accepted frame advance. Both counters wrap naturally. They are 5 bits wide when BIG_MEM=1 and 4 bits wide when BIG_MEM=0.
- R3: The number of stored frames is `fin_cnt - fout_cnt` modulo the counter range. At most 31 frames can be held (BIG_MEM=1), or 15 frames (BIG_MEM=0). Completing one more frame while at that limit sets `ovf`, and the frame count wraps to zero.
- R4: At most 2^ADDR_W-1 unread bytes can be held. A write that would reach 2^ADDR_W unread bytes sets `ovf`. The writer keeps going and overwrites the oldest bytes.
- R5: Once set, `ovf` stays high until `rst` or `fifo_clr` is asserted.
- R6: A `rd_en` pulse is accepted when `rbyte_cnt` differs from `wbyte_cnt`. On the next cycle, `rd_data` shows the byte at the old read position and `rbyte_cnt` has increased by one. When the two pointers are equal, `rd_en` is ignored: `rbyte_cnt`, `rd_data` and `rd_last` keep their values.
- R7: `rd_last` is updated together with `rd_data`. It is 1 when the byte read is the final byte of the oldest stored frame.
- R8: A `rd_adv` pulse is accepted when at least one frame is stored. It increments `fout_cnt` and moves `rbyte_cnt` to the end of the frame it retires, skipping any unread bytes of that frame. With no stored frame, `rd_adv` is ignored. An accepted advance takes priority over `rd_en` in the same cycle.
- R9: A write with `wr_sof` high places its byte at the start of the frame currently being written. Any bytes of that frame not yet closed are discarded. A byte with both `wr_sof` and `wr_eof` high forms a one-byte frame.
- R10: When a frame is completed in the same cycle as an accepted advance, the stored frame count is unchanged. If the count is at its limit, no overflow is flagged.
- R11: `fifo_clr` clears all four counters, `ovf`, `rd_data` and `rd_last` on the next edge.
- R12: Reset is synchronous and active high. It leaves every output at zero. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_clr | input | 1 | FIFO clear, used to recover from overflow |
| wr_en | input | 1 | Byte write strobe |
| wr_sof | input | 1 | Byte starts a frame |
| wr_eof | input | 1 | Byte ends a frame |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read strobe |
| rd_adv | input | 1 | Frame-advance strobe |
| rd_data | output | 8 | Byte read out, one cycle after an accepted read |
| rd_last | output | 1 | Byte read was the final byte of its frame |
| fin_cnt | output | BIG_MEM?5:4 | Input frame counter |
| fout_cnt | output | BIG_MEM?5:4 | Output frame counter |
| wbyte_cnt | output | ADDR_W | Byte write pointer |
| rbyte_cnt | output | ADDR_W | Byte read pointer |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The interaction most likely to fail is a frame completion falling in the same cycle as a frame advance. Both paths move the frame counters, and the overflow test must use the output counter after the advance. The bench provokes this twice. The first time is a one-byte frame written while the reader advances past an older frame. The second time is the same collision with 31 frames already stored, where a wrong comparison would raise `ovf`. The bench judges both cases by the frame count staying constant, by the read pointer jumping to the retired frame's end, and by `ovf` staying low.

// File: rtl/frx_pkg.sv
package frx_pkg;
  // frame counter width chosen by the memory size option
  function automatic int frm_w(bit big);
    return big ? 5 : 4;
  endfunction
endpackage

// File: rtl/frx_frame_ctrl.sv
module frx_frame_ctrl #(
  parameter int FW = 5,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          commit,
  input  logic [AW-1:0] commit_end,
  input  logic          adv_req,
  output logic [FW-1:0] fin,
  output logic [FW-1:0] fout,
  output logic          adv_ok,
  output logic [AW-1:0] head_end,
  output logic          frm_ovf
);
  localparam int SLOTS = 2 ** FW;
  localparam logic [FW-1:0] MAXF = FW'(SLOTS - 1);

  logic [AW-1:0] marks [SLOTS];
  logic [FW-1:0] fin_nx, fout_nx, occ;

  assign adv_ok   = adv_req && (fin != fout);
  assign head_end = marks[fout];
  assign fin_nx   = FW'(fin + FW'(1));
  assign fout_nx  = adv_ok ? FW'(fout + FW'(1)) : fout;
  assign frm_ovf  = commit && (fin_nx == fout_nx);
  assign occ      = FW'(fin - fout);

  always_ff @(posedge clk) begin
    if (clr) begin
      fin  <= '0;
      fout <= '0;
    end else begin
      if (commit) fin <= fin_nx;
      fout <= fout_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) marks[fin] <= commit_end;
  end

  // R3
  frm_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    commit && !adv_ok && occ == MAXF |=> fin == fout);
  // R2
  fin_step_chk: assert property (@(posedge clk) disable iff (clr)
    commit |=> fin == FW'($past(fin) + FW'(1)));
  // R8
  adv_empty_chk: assert property (@(posedge clk) disable iff (clr)
    adv_req && fin == fout |=> fout == $past(fout));
  // R10
  both_chk: assert property (@(posedge clk) disable iff (clr)
    commit && adv_ok |=> $stable(occ));
endmodule

// File: rtl/frx_byte_store.sv
module frx_byte_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic          wr_sof,
  input  logic          wr_eof,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic          adv_ok,
  input  logic [AW-1:0] adv_ptr,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] commit_end,
  output logic [7:0]    rd_data,
  output logic          rd_go,
  output logic          mem_ovf
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] fstart, waddr, rnext;

  assign waddr      = wr_sof ? fstart : wptr;
  assign commit_end = AW'(waddr + AW'(1));
  assign rd_go      = rd_en && !adv_ok && (rptr != wptr);
  assign rnext      = adv_ok ? adv_ptr : (rd_go ? AW'(rptr + AW'(1)) : rptr);
  assign mem_ovf    = wr_en && (commit_end == rnext);

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr   <= '0;
      rptr   <= '0;
      fstart <= '0;
    end else begin
      if (wr_en) begin
        wptr <= commit_end;
        if (wr_eof) fstart <= commit_end;
      end
      rptr <= rnext;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (clr) rd_data <= '0;
    else if (rd_go) rd_data <= mem[rptr];
  end

  // R1
  wr_adv_chk: assert property (@(posedge clk) disable iff (clr)
    wr_en && !wr_sof |=> wptr == AW'($past(wptr) + AW'(1)));
  // R6
  rd_empty_chk: assert property (@(posedge clk) disable iff (clr)
    rd_en && !adv_ok && rptr == wptr |=> rptr == $past(rptr) && $stable(rd_data));
  // R8
  adv_jump_chk: assert property (@(posedge clk) disable iff (clr)
    adv_ok |=> rptr == $past(adv_ptr));
  // R9
  sof_chk: assert property (@(posedge clk) disable iff (clr)
    wr_en && wr_sof |=> wptr == AW'($past(fstart) + AW'(1)));
endmodule

// File: rtl/frame_rx_fifo.sv
module frame_rx_fifo #(
  parameter bit BIG_MEM = 1'b1,
  parameter int ADDR_W  = 6,
  localparam int FW     = frx_pkg::frm_w(BIG_MEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_clr,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              rd_adv,
  output logic [7:0]        rd_data,
  output logic              rd_last,
  output logic [FW-1:0]     fin_cnt,
  output logic [FW-1:0]     fout_cnt,
  output logic [ADDR_W-1:0] wbyte_cnt,
  output logic [ADDR_W-1:0] rbyte_cnt,
  output logic              ovf
);
  logic              clr, adv_ok, frm_ovf, mem_ovf, rd_go;
  logic [ADDR_W-1:0] commit_end, head_end;

  assign clr = rst || fifo_clr;

  frx_frame_ctrl #(.FW(FW), .AW(ADDR_W)) u_frm (
    .clk(clk), .clr(clr),
    .commit(wr_en && wr_eof), .commit_end(commit_end),
    .adv_req(rd_adv),
    .fin(fin_cnt), .fout(fout_cnt),
    .adv_ok(adv_ok), .head_end(head_end), .frm_ovf(frm_ovf)
  );

  frx_byte_store #(.AW(ADDR_W)) u_mem (
    .clk(clk), .clr(clr),
    .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_data(wr_data),
    .rd_en(rd_en), .adv_ok(adv_ok), .adv_ptr(head_end),
    .wptr(wbyte_cnt), .rptr(rbyte_cnt), .commit_end(commit_end),
    .rd_data(rd_data), .rd_go(rd_go), .mem_ovf(mem_ovf)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_last <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (rd_go)
        rd_last <= (fin_cnt != fout_cnt) &&
                   (ADDR_W'(rbyte_cnt + ADDR_W'(1)) == head_end);
      if (frm_ovf || mem_ovf) ovf <= 1'b1;
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf && !fifo_clr |=> ovf);
  // R11
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> fin_cnt == '0 && fout_cnt == '0 && wbyte_cnt == '0 &&
                 rbyte_cnt == '0 && !ovf);
endmodule

// File: tb/tb_frame_rx_fifo.sv
module tb_frame_rx_fifo;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, fifo_clr, wr_en, wr_sof, wr_eof, rd_en, rd_adv;
  logic [7:0] wr_data;
  logic [7:0] rd_data, rd_data_s;
  logic rd_last, rd_last_s, ovf, ovf_s;
  logic [4:0] fin_cnt, fout_cnt;
  logic [3:0] fin_s, fout_s;
  logic [5:0] wbyte_cnt, rbyte_cnt, wb_s, rb_s;

  frame_rx_fifo #(.BIG_MEM(1'b1), .ADDR_W(6)) dut (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_sof(wr_sof),
    .wr_eof(wr_eof), .wr_data(wr_data), .rd_en(rd_en), .rd_adv(rd_adv),
    .rd_data(rd_data), .rd_last(rd_last), .fin_cnt(fin_cnt), .fout_cnt(fout_cnt),
    .wbyte_cnt(wbyte_cnt), .rbyte_cnt(rbyte_cnt), .ovf(ovf));

  frame_rx_fifo #(.BIG_MEM(1'b0), .ADDR_W(6)) dut_s (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_sof(wr_sof),
    .wr_eof(wr_eof), .wr_data(wr_data), .rd_en(rd_en), .rd_adv(rd_adv),
    .rd_data(rd_data_s), .rd_last(rd_last_s), .fin_cnt(fin_s), .fout_cnt(fout_s),
    .wbyte_cnt(wb_s), .rbyte_cnt(rb_s), .ovf(ovf_s));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic we, sof, eof; logic [7:0] d; logic re, adv;
    logic [4:0] fin, fout; logic [5:0] wp, rp;
    logic ovf, crd; logic [7:0] rdd; logic rdl;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1'b1,1'b1,1'b0,8'hA1,1'b0,1'b0, 5'd1-5'd1,5'd0,6'd1,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,8'hA2,1'b0,1'b0, 5'd1,5'd0,6'd2,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b1,1'b0,8'hB1,1'b0,1'b0, 5'd1,5'd0,6'd3,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,8'hB2,1'b0,1'b0, 5'd1,5'd0,6'd4,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b1,1'b0,8'hC1,1'b0,1'b0, 5'd1,5'd0,6'd3,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,8'hC2,1'b0,1'b0, 5'd2,5'd0,6'd4,6'd0,1'b0,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 5'd2,5'd0,6'd4,6'd1,1'b0,1'b1,8'hA1,1'b0},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 5'd2,5'd1,6'd4,6'd2,1'b0,1'b0,8'h00,1'b0},
    '{1'b1,1'b1,1'b1,8'hD1,1'b0,1'b1, 5'd3,5'd2,6'd5,6'd4,1'b0,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 5'd3,5'd2,6'd5,6'd5,1'b0,1'b1,8'hD1,1'b1},
    '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0, 5'd3,5'd2,6'd5,6'd5,1'b0,1'b1,8'hD1,1'b1},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 5'd3,5'd3,6'd5,6'd5,1'b0,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1, 5'd3,5'd3,6'd5,6'd5,1'b0,1'b0,8'h00,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs applied at a falling edge, held over one rising edge, released
  task automatic cyc(input logic we, sof, eof, input logic [7:0] d, input logic re, adv);
    wr_en = we; wr_sof = sof; wr_eof = eof; wr_data = d; rd_en = re; rd_adv = adv;
    @(negedge clk);
    wr_en = 0; wr_sof = 0; wr_eof = 0; wr_data = 0; rd_en = 0; rd_adv = 0;
  endtask

  task automatic clear_fifo();
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic one_byte_frames(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 8'(i), 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; fifo_clr = 0; wr_en = 0; wr_sof = 0; wr_eof = 0; wr_data = 0;
    rd_en = 0; rd_adv = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 reset counters", {fin_cnt, fout_cnt, wbyte_cnt, rbyte_cnt}, 0);
    chk("R12 reset flags", {ovf, rd_last, rd_data}, 0);

    // table walk: SOF restart, reads, advances, collisions, ignored strobes
    foreach (TBL[i]) begin
      cyc(TBL[i].we, TBL[i].sof, TBL[i].eof, TBL[i].d, TBL[i].re, TBL[i].adv);
      chk("R2 fin_cnt", fin_cnt, TBL[i].fin);
      chk("R2 R8 fout_cnt", fout_cnt, TBL[i].fout);
      chk("R1 R9 wbyte_cnt", wbyte_cnt, TBL[i].wp);
      chk("R6 R8 rbyte_cnt", rbyte_cnt, TBL[i].rp);
      chk("R5 ovf", ovf, TBL[i].ovf);
      if (TBL[i].crd) begin
        chk("R6 rd_data", rd_data, TBL[i].rdd);
        chk("R7 rd_last", rd_last, TBL[i].rdl);
      end
    end

    // R3 frame count wrap in the large configuration
    clear_fifo();
    one_byte_frames(31);
    chk("R3 31 frames held", 5'(fin_cnt - fout_cnt), 31);
    chk("R3 no ovf at 31", ovf, 0);
    one_byte_frames(1);
    chk("R3 32nd frame sets ovf", ovf, 1);
    chk("R3 count wraps to zero", 5'(fin_cnt - fout_cnt), 0);
    chk("R1 writer not stalled", wbyte_cnt, 32);
    cyc(1, 1, 1, 8'h11, 1, 0);
    chk("R5 ovf stays set", ovf, 1);

    // R11 FIFO clear
    clear_fifo();
    chk("R11 clear counters", {fin_cnt, fout_cnt, wbyte_cnt, rbyte_cnt}, 0);
    chk("R11 clear flags", {ovf, rd_last, rd_data}, 0);

    // R10 completion and advance collide at the frame limit
    one_byte_frames(31);
    cyc(1, 1, 1, 8'h77, 0, 1);
    chk("R10 fin after collision", fin_cnt, 0);
    chk("R10 fout after collision", fout_cnt, 1);
    chk("R10 count unchanged", 5'(fin_cnt - fout_cnt), 31);
    chk("R10 no ovf", ovf, 0);
    chk("R8 read pointer at frame end", rbyte_cnt, 1);

    // R4 data memory overrun
    clear_fifo();
    for (int i = 0; i < 63; i++) cyc(1, 0, 0, 8'(i), 0, 0);
    chk("R4 63 bytes no ovf", ovf, 0);
    chk("R1 63 bytes stored", wbyte_cnt, 63);
    cyc(1, 0, 0, 8'hEE, 0, 0);
    chk("R4 64th byte sets ovf", ovf, 1);
    chk("R1 pointer wraps", wbyte_cnt, 0);
    cyc(1, 0, 0, 8'h5A, 0, 0);
    chk("R1 keeps writing", wbyte_cnt, 1);
    cyc(0, 0, 0, 8'h00, 1, 0);
    chk("R4 oldest byte overwritten", rd_data, 8'h5A);
    chk("R5 ovf held", ovf, 1);

    // R3 small configuration: 15 frames
    clear_fifo();
    one_byte_frames(15);
    chk("R3 small 15 frames", 4'(fin_s - fout_s), 15);
    chk("R3 small no ovf", ovf_s, 0);
    one_byte_frames(1);
    chk("R3 small 16th sets ovf", ovf_s, 1);
    chk("R2 small fin wraps", fin_s, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule